// File: doc/BRIEF.md
# Signed Energy Pulse-Rate Generator

This block turns a stream of signed energy samples into pulses on two output pins. Each time the sample strobe is high, the sample is multiplied by a programmable rate word and added to a signed accumulator. Every whole pulse quantum in the accumulator becomes one pending pulse. The fraction that is left stays in the accumulator for the next sample. A single sample can therefore release a burst of several pulses. These pulses wait in a signed pending count and go out one at a time with a fixed shape.

In the normal mode, the first pin carries the energy pulses and the second pin gives their direction: high for negative (reverse) energy. The direction is settled before each pulse rises. In the alternating mode, each pulse instead flips one of the two pins, taking the pins in turn, and the sign of the energy is not shown. The energy computation upstream and any calibration stay outside the block.

Top module: `energy_pulse_gen`

## Requirements
- R1: While reset is low at a clock edge, the accumulator, the pending count and the pulse sequencer are cleared, and both pins are driven to 0.
- R2: When the strobe is low, the sample and rate inputs have no effect. No pulse appears that the strobed samples did not cause.
- R3: On each strobe, sample × rate is added to the accumulator. The quantum is 2^(SAMPLE_W−1+RATE_FRAC). The whole quanta in the sum are truncated toward zero and become that many pulses. The signed remainder is kept for the next sample, so two half-quantum samples produce exactly one pulse.
- R4: A rate word of 32768 (8 × 2^RATE_FRAC with RATE_FRAC = 12) makes one full-scale sample (−2^23) produce exactly 8 pulses.
- R5: In the normal mode, each pulse is high for PULSE_HI clocks. Consecutive pulses of one burst are separated by exactly PULSE_LO+2 low clocks.
- R6: In the normal mode, the direction pin is 1 for pulses from negative energy and 0 for positive energy. It changes at least one clock before the pulse rises and holds steady while the pulse is high.
- R7: Pending pulses form one signed net count. A burst of the opposite sign cancels pending pulses instead of being emitted, so +E followed at once by −E gives no pulse.
- R8: The pending count saturates at ±(2^(PEND_W−1)−1). Pulses beyond that limit are dropped.
- R9: In the alternating mode, each pulse inverts exactly one pin. The pins take turns, and the energy pin goes first after reset. Pulses of both signs count.
- R10: Pulses from a later sample queue behind the pulses still pending and keep the same spacing as one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb_i | input | 1 | Sample strobe, one clock per sample |
| smp_energy_i | input | SAMPLE_W (24) | Signed two's complement energy sample |
| rate_i | input | RATE_W (16) | Unsigned pulse-rate word, RATE_FRAC fraction bits |
| alt_mode_i | input | 1 | 0 = pulse plus direction, 1 = alternating pin toggle |
| epulse_o | output | 1 | Energy pulse pin |
| edir_o | output | 1 | Direction pin, or second toggle pin |

## Verification
The bench builds the block with PULSE_HI = 2, PULSE_LO = 3 and PEND_W = 5, and keeps the default 24-bit sample, the 16-bit rate and RATE_FRAC = 12. The short pulse shape lets a full eight-pulse burst drain in about sixty clocks. The five-bit pending count saturates at 15, so three back-to-back full-scale samples reach the clamp. The exact quantum of 2^35 lets half-scale and full-scale samples give known pulse counts, including carry-over and truncation toward zero for negative sums.

// File: rtl/epg_pkg.sv
// Package: shared types for the energy pulse-rate generator.
// Assumes: nothing beyond IEEE 1800-2017.
package epg_pkg;

    // Pulse sequencer phases: wait, settle direction, drive high, hold low.
    typedef enum logic [1:0] {
        EM_IDLE  = 2'd0,
        EM_SETUP = 2'd1,
        EM_HIGH  = 2'd2,
        EM_LOW   = 2'd3
    } emit_state_e;

endpackage

// File: rtl/epg_accum.sv
// Module: epg_accum
// Multiplies each strobed signed sample by the unsigned rate word and adds
// the product to a signed accumulator. It splits the sum into whole quanta
// (truncated toward zero) and a signed remainder, which it keeps.
// Assumes: the quantum is 2^(SAMPLE_W-1+RATE_FRAC), and BURST_W is wide
// enough for the largest whole-quanta count of one sample.
module epg_accum #(
    parameter int SAMPLE_W  = 24,
    parameter int RATE_W    = 16,
    parameter int RATE_FRAC = 12,
    parameter int BURST_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [RATE_W-1:0]   rate_i,
    output logic signed [BURST_W-1:0]  burst_o,
    output logic                       burst_vld_o
);

    localparam int QSH    = SAMPLE_W - 1 + RATE_FRAC;
    localparam int PROD_W = SAMPLE_W + RATE_W + 1;
    localparam int ACC_W  = PROD_W + 1;
    localparam logic [ACC_W-1:0] FRAC_MASK = (ACC_W'(1) << QSH) - ACC_W'(1);

    logic signed [ACC_W-1:0]   acc_q;
    logic signed [PROD_W-1:0]  prod;
    logic signed [ACC_W-1:0]   sum;
    logic        [ACC_W-1:0]   mag;
    logic        [ACC_W-1:0]   frac;
    logic        [BURST_W-1:0] bmag;
    logic signed [ACC_W-1:0]   rem_s;
    logic signed [BURST_W-1:0] nburst;

    // Form the product and the new sum, then split it into quanta and remainder.
    always_comb begin
        prod   = sample_i * $signed({1'b0, rate_i});
        sum    = acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        mag    = sum[ACC_W-1] ? $unsigned(-sum) : $unsigned(sum);
        bmag   = BURST_W'(mag >> QSH);
        frac   = mag & FRAC_MASK;
        rem_s  = sum[ACC_W-1] ? -$signed(frac) : $signed(frac);
        nburst = sum[ACC_W-1] ? -$signed(bmag) : $signed(bmag);
    end

    // Register the remainder and publish the burst count for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= '0;
            burst_o     <= '0;
            burst_vld_o <= 1'b0;
        end else if (strobe_i) begin
            acc_q       <= rem_s;
            burst_o     <= nburst;
            burst_vld_o <= 1'b1;
        end else begin
            burst_vld_o <= 1'b0;
        end
    end

    logic [ACC_W-1:0] acc_abs;
    // Magnitude of the stored remainder, for the bound check below.
    always_comb acc_abs = acc_q[ACC_W-1] ? $unsigned(-acc_q) : $unsigned(acc_q);

    // R3
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_abs >> QSH) == '0);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> ($stable(acc_q) && !burst_vld_o));

endmodule

// File: rtl/epg_pend.sv
// Module: epg_pend
// Keeps the signed net count of pulses still to be emitted. Each new burst
// is added, each consumed pulse moves the count one step toward zero, and
// the result saturates at +/-(2^(PEND_W-1)-1).
// Assumes: consume_i is only asserted while the count is non-zero.
module epg_pend #(
    parameter int BURST_W = 6,
    parameter int PEND_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic signed [BURST_W-1:0] burst_i,
    input  logic                      burst_vld_i,
    input  logic                      consume_i,
    output logic signed [PEND_W-1:0]  pend_o
);

    localparam int SUM_W = ((PEND_W > BURST_W) ? PEND_W : BURST_W) + 2;
    localparam logic signed [SUM_W-1:0] PMAX = SUM_W'((1 << (PEND_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] PMIN = -PMAX;

    logic signed [SUM_W-1:0] add_v;
    logic signed [SUM_W-1:0] dec_v;
    logic signed [SUM_W-1:0] next_v;
    logic signed [SUM_W-1:0] clip_v;

    // Combine the new burst and the consumed pulse, then clamp.
    always_comb begin
        add_v  = burst_vld_i ? SUM_W'(burst_i) : '0;
        dec_v  = consume_i ? (pend_o[PEND_W-1] ? -SUM_W'(1) : SUM_W'(1)) : '0;
        next_v = SUM_W'(pend_o) + add_v - dec_v;
        if (next_v > PMAX)      clip_v = PMAX;
        else if (next_v < PMIN) clip_v = PMIN;
        else                    clip_v = next_v;
    end

    // Hold the pending count.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= PEND_W'(clip_v);
    end

    // R8
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SUM_W'(pend_o) <= PMAX) && (SUM_W'(pend_o) >= PMIN));

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SUM_W'(pend_o) == PMAX && burst_vld_i && burst_i > 0 && !consume_i)
        |=> (SUM_W'(pend_o) == PMAX));

endmodule

// File: rtl/epg_emit.sv
// Module: epg_emit
// Sequences pulses out of the pending count. In the normal mode it latches
// the direction, waits one clock, drives the pulse high for PULSE_HI clocks
// and then low for PULSE_LO clocks. In the alternating mode it inverts one
// of two toggle registers per pulse, taking them in turn.
// Assumes: PULSE_HI >= 1, PULSE_LO >= 1, and the mode changes only while
// no pulse is in flight.
module epg_emit
    import epg_pkg::*;
#(
    parameter int PULSE_HI = 4,
    parameter int PULSE_LO = 4,
    parameter int PEND_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alt_mode_i,
    input  logic signed [PEND_W-1:0] pend_i,
    output logic                     consume_o,
    output logic                     eout_o,
    output logic                     dir_o
);

    localparam int CNT_MAX = (PULSE_HI > PULSE_LO) ? PULSE_HI : PULSE_LO;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(PULSE_HI - 1);
    localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(PULSE_LO - 1);

    emit_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             tog_e_q;
    logic             tog_d_q;
    logic             sel_q;
    logic             pend_nz;
    logic             pend_neg;

    // Decode the pending count and decide whether the pulse may start.
    always_comb begin
        pend_nz   = (pend_i != '0);
        pend_neg  = pend_i[PEND_W-1];
        consume_o = (state_q == EM_SETUP) && pend_nz && (pend_neg == dir_q);
    end

    // Advance the pulse sequencer and the toggle registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EM_IDLE;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
            tog_e_q <= 1'b0;
            tog_d_q <= 1'b0;
            sel_q   <= 1'b0;
        end else begin
            case (state_q)
                EM_IDLE: begin
                    if (pend_nz) begin
                        dir_q   <= pend_neg;
                        state_q <= EM_SETUP;
                    end
                end
                EM_SETUP: begin
                    if (consume_o) begin
                        state_q <= EM_HIGH;
                        cnt_q   <= '0;
                        if (alt_mode_i) begin
                            if (sel_q) tog_d_q <= ~tog_d_q;
                            else       tog_e_q <= ~tog_e_q;
                            sel_q <= ~sel_q;
                        end
                    end else begin
                        state_q <= EM_IDLE;
                    end
                end
                EM_HIGH: begin
                    if (cnt_q == HI_LAST) begin
                        state_q <= EM_LOW;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == LO_LAST) state_q <= EM_IDLE;
                    else                  cnt_q   <= cnt_q + 1'b1;
                end
            endcase
        end
    end

    // Select the pin drivers for the active mode.
    always_comb begin
        eout_o = alt_mode_i ? tog_e_q : (state_q == EM_HIGH);
        dir_o  = alt_mode_i ? tog_d_q : dir_q;
    end

    // R5
    hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EM_HIGH && cnt_q == HI_LAST) |=> (state_q == EM_LOW));

    // R5
    lo_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EM_LOW && cnt_q != LO_LAST) |=> (state_q == EM_LOW));

    // R6
    dir_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_mode_i && $stable(alt_mode_i) && $rose(eout_o)) |-> $stable(dir_o));

    // R6
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_mode_i && eout_o) |=> (!eout_o || $stable(dir_o)));

    // R9
    alt_one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_mode_i && $stable(alt_mode_i))
        |-> ($countones({eout_o ^ $past(eout_o), dir_o ^ $past(dir_o)}) <= 1));

endmodule

// File: rtl/energy_pulse_gen.sv
// Module: energy_pulse_gen
// Top level: accumulator, net pending count and pulse sequencer in a chain.
// The first pulse appears three clocks after the strobe edge.
// Assumes: one strobe per sample period, and the rate and mode are held
// stable while pulses are in flight.
module energy_pulse_gen #(
    parameter int SAMPLE_W  = 24,
    parameter int RATE_W    = 16,
    parameter int RATE_FRAC = 12,
    parameter int PEND_W    = 8,
    parameter int PULSE_HI  = 4,
    parameter int PULSE_LO  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb_i,
    input  logic [SAMPLE_W-1:0] smp_energy_i,
    input  logic [RATE_W-1:0]   rate_i,
    input  logic                alt_mode_i,
    output logic                epulse_o,
    output logic                edir_o
);

    localparam int BURST_W = RATE_W - RATE_FRAC + 2;

    logic signed [BURST_W-1:0] burst;
    logic                      burst_vld;
    logic signed [PEND_W-1:0]  pend;
    logic                      consume;

    epg_accum #(
        .SAMPLE_W (SAMPLE_W),
        .RATE_W   (RATE_W),
        .RATE_FRAC(RATE_FRAC),
        .BURST_W  (BURST_W)
    ) accum_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (smp_stb_i),
        .sample_i   ($signed(smp_energy_i)),
        .rate_i     (rate_i),
        .burst_o    (burst),
        .burst_vld_o(burst_vld)
    );

    epg_pend #(
        .BURST_W(BURST_W),
        .PEND_W (PEND_W)
    ) pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_i    (burst),
        .burst_vld_i(burst_vld),
        .consume_i  (consume),
        .pend_o     (pend)
    );

    epg_emit #(
        .PULSE_HI(PULSE_HI),
        .PULSE_LO(PULSE_LO),
        .PEND_W  (PEND_W)
    ) emit_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alt_mode_i(alt_mode_i),
        .pend_i    (pend),
        .consume_o (consume),
        .eout_o    (epulse_o),
        .dir_o     (edir_o)
    );

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!epulse_o && !edir_o));

endmodule

// File: tb/energy_pulse_gen_tb.sv
module energy_pulse_gen_tb_top;

    localparam int HI   = 2;
    localparam int LO   = 3;
    localparam int PW   = 5;
    localparam int PMAX = 15;
    localparam longint QNT = 64'sd1 <<< 35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stb = 1'b0;
    logic [23:0] smp = '0;
    logic [15:0] rate = 16'd32768;
    logic        mode = 1'b0;
    logic        epulse;
    logic        edir;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    energy_pulse_gen #(
        .PEND_W  (PW),
        .PULSE_HI(HI),
        .PULSE_LO(LO)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_stb_i   (stb),
        .smp_energy_i(smp),
        .rate_i      (rate),
        .alt_mode_i  (mode),
        .epulse_o    (epulse),
        .edir_o      (edir)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced at every rising edge.
    longint m_acc, m_sum, m_n;
    int  m_bq, m_pend, m_np, m_st, m_cnt, o_pend;
    bit  m_bv, m_dir, m_te, m_td, m_sel, m_cons;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_bq = 0; m_bv = 0; m_pend = 0; m_st = 0; m_cnt = 0;
            m_dir = 0; m_te = 0; m_td = 0; m_sel = 0;
        end else begin
            o_pend = m_pend;
            m_cons = (m_st == 1) && (o_pend != 0) && ((o_pend < 0) == m_dir);
            m_np = o_pend + (m_bv ? m_bq : 0) - (m_cons ? ((o_pend < 0) ? -1 : 1) : 0);
            if (m_np > PMAX) m_np = PMAX;
            if (m_np < -PMAX) m_np = -PMAX;
            if (stb) begin
                m_sum = m_acc + longint'($signed(smp)) * longint'(rate);
                m_n   = m_sum / QNT;
                m_acc = m_sum - m_n * QNT;
                m_bq  = int'(m_n);
                m_bv  = 1;
            end else begin
                m_bv = 0;
            end
            case (m_st)
                0: if (o_pend != 0) begin m_dir = (o_pend < 0); m_st = 1; end
                1: if (m_cons) begin
                       m_st = 2; m_cnt = 0;
                       if (mode) begin
                           if (m_sel) m_td = ~m_td; else m_te = ~m_te;
                           m_sel = ~m_sel;
                       end
                   end else m_st = 0;
                2: if (m_cnt == HI - 1) begin m_st = 3; m_cnt = 0; end else m_cnt++;
                default: if (m_cnt == LO - 1) m_st = 0; else m_cnt++;
            endcase
            m_pend = m_np;
        end
    end

    // Per-cycle comparison and pulse-shape monitor.
    bit p_e, p_d, seen, first_set, first_is_e;
    int rises, neg_rises, width_bad, gap_bad, setup_bad, e_tog, d_tog, hi_run, lo_run;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(epulse == (mode ? m_te : (m_st == 2)), mode ? "R9" : "R5",
                "epulse vs model", epulse, mode ? m_te : (m_st == 2));
            chk(edir == (mode ? m_td : m_dir), mode ? "R9" : "R6",
                "edir vs model", edir, mode ? m_td : m_dir);
            if (epulse != p_e) begin e_tog++; if (!first_set) begin first_set = 1; first_is_e = 1; end end
            if (edir != p_d && mode) begin d_tog++; if (!first_set) begin first_set = 1; first_is_e = 0; end end
            if (!mode) begin
                if (epulse && !p_e) begin
                    rises++;
                    if (edir) neg_rises++;
                    if (edir != p_d) setup_bad++;
                    if (seen && lo_run != LO + 2) gap_bad++;
                    seen = 1; hi_run = 1; lo_run = 0;
                end else if (epulse) begin
                    hi_run++;
                    if (edir != p_d) setup_bad++;
                end else if (p_e) begin
                    if (hi_run != HI) width_bad++;
                    lo_run = 1;
                end else begin
                    lo_run++;
                end
            end
        end
        p_e = epulse;
        p_d = edir;
    end

    task automatic clear_mon();
        rises = 0; neg_rises = 0; width_bad = 0; gap_bad = 0; setup_bad = 0;
        e_tog = 0; d_tog = 0; seen = 0; first_set = 0; first_is_e = 0;
        hi_run = 0; lo_run = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit alt);
        @(negedge clk);
        rst_n = 1'b0; stb = 1'b0; mode = alt;
        idle(3);
        rst_n = 1'b1;
        clear_mon();
    endtask

    task automatic strobe(input logic [23:0] v);
        smp = v; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0; smp = 24'h5A5A5A;
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        // R1: pins idle after reset
        chk(epulse == 0 && edir == 0, "R1", "pins after reset", {epulse, edir}, 0);
        // R2: unstrobed samples have no effect
        for (int i = 0; i < 30; i++) begin
            smp = 24'h800000 + 24'(i * 977);
            @(negedge clk);
        end
        strobe(24'h000000);
        idle(20);
        chk(rises == 0, "R2", "pulses with strobe low", rises, 0);

        // R4, R5, R6: full-scale negative sample at the default rate
        clear_mon();
        strobe(24'h800000);
        idle(80);
        chk(rises == 8, "R4", "pulses per full-scale sample", rises, 8);
        chk(neg_rises == 8, "R6", "negative direction pulses", neg_rises, 8);
        chk(width_bad == 0, "R5", "high-time violations", width_bad, 0);
        chk(gap_bad == 0, "R5", "gap violations", gap_bad, 0);
        chk(setup_bad == 0, "R6", "direction not settled", setup_bad, 0);

        // R3: half-quantum samples carry their remainder
        rate = 16'd4096;
        clear_mon();
        for (int i = 0; i < 4; i++) begin strobe(24'h400000); idle(20); end
        chk(rises == 2, "R3", "pulses from four half quanta", rises, 2);
        chk(neg_rises == 0, "R6", "positive direction", neg_rises, 0);
        clear_mon();
        strobe(24'hC00000);
        idle(20);
        chk(rises == 0, "R3", "negative half truncates toward zero", rises, 0);
        strobe(24'hC00000);
        idle(20);
        chk(rises == 1 && neg_rises == 1, "R3", "negative carry pulse", rises, 1);

        // R7: opposite bursts back to back cancel
        rate = 16'd32768;
        clear_mon();
        smp = 24'h400000; stb = 1'b1;
        @(negedge clk);
        smp = 24'hC00000;
        @(negedge clk);
        stb = 1'b0;
        idle(40);
        chk(rises == 0, "R7", "net zero energy pulses", rises, 0);

        // R10: a second burst queues behind the first
        clear_mon();
        strobe(24'h400000);
        idle(3);
        strobe(24'h400000);
        idle(80);
        chk(rises == 8, "R10", "queued pulses", rises, 8);
        chk(gap_bad == 0, "R10", "queued gap violations", gap_bad, 0);

        // R8: saturation of the pending count
        do_reset(1'b0);
        clear_mon();
        smp = 24'h800000; stb = 1'b1;
        idle(3);
        stb = 1'b0;
        idle(150);
        chk(rises == 16, "R8", "pulses after saturation", rises, 16);

        // R9: alternating mode
        do_reset(1'b1);
        strobe(24'h300000);
        idle(40);
        chk(e_tog == 2 && d_tog == 1, "R9", "toggle counts e*10+d", e_tog * 10 + d_tog, 21);
        chk(first_is_e == 1, "R9", "first toggled pin is energy pin", first_is_e, 1);
        chk(epulse == 0 && edir == 1, "R9", "pin levels", {epulse, edir}, 1);
        strobe(24'hF00000);
        idle(20);
        chk(d_tog == 2 && edir == 0, "R9", "negative pulse toggles next pin", d_tog, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule